// File: doc/BRIEF.md
# Word-Packed UART Transmitter

This block is a serial transmitter whose input queue holds 32-bit words instead of single characters. Each queue entry packs up to four characters. Software first writes the number of characters in a transfer, then writes packed words into the queue. The engine takes the characters out of each word, starting with the lowest byte, and sends each one on an asynchronous serial line with eight data bits, no parity and one stop bit.

The programmed character count decides how many bytes of the last word go on the line. Any byte above that count is dropped. Status outputs show whether the queue can take another word and whether it is empty. A sticky event flag reports that a whole transfer has left the line, and a command write clears it. A second command aborts the transmitter.

Bit timing comes from an external baud tick. One bit period lasts sixteen ticks.

Top module: `uart_word_tx`

## Requirements
- R1: After reset, `txd_o` is 1, `fifo_empty_o` and `fifo_space_o` are 1, and `tx_ready_evt_o` and `overflow_err_o` are 0.
- R2: Characters leave a word in byte order. Bits 7:0 go first, then 15:8, then 23:16, then 31:24.
- R3: Each character is one frame. The frame is a start bit of 0, then eight data bits LSB first, then a stop bit of 1. Every bit lasts TICKS_PER_BIT baud ticks, and the line is 1 between frames.
- R4: A write to the count port sets the number of characters still to send. Each character sent lowers that number by one. Bytes of a word above the remaining count are never sent.
- R5: `fifo_space_o` is 1 while the queue holds fewer than FIFO_DEPTH words. `fifo_empty_o` is 1 while it holds none.
- R6: `tx_ready_evt_o` becomes 1 once the stop bit of the character that brings the count to zero has finished. It stays 0 while that transfer is still on the line, and it holds its value until cleared.
- R7: A command write with `cmd_i[1]`=1 clears `tx_ready_evt_o`. It does not change `overflow_err_o`.
- R8: A data write while the queue is full is dropped and sets `overflow_err_o`, which stays set. While the remaining count is zero, words stay queued and nothing is sent.
- R9: A command write with `cmd_i[0]`=1 does all of the following:
  - empties the queue;
  - aborts any frame in progress and returns the line to 1;
  - sets the remaining count to zero;
  - clears `overflow_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_we_i | input | 1 | Write strobe for the character count |
| cnt_wdata_i | input | CNT_W | Number of characters in the transfer |
| data_we_i | input | 1 | Write strobe for the packed data word |
| data_wdata_i | input | 32 | Packed data word, first character in bits 7:0 |
| cmd_we_i | input | 1 | Write strobe for the command port |
| cmd_i | input | 2 | Bit 0 resets the transmitter, bit 1 clears the event flag |
| baud_tick_i | input | 1 | One-cycle tick, sixteen per bit |
| txd_o | output | 1 | Serial line, idles high |
| fifo_space_o | output | 1 | Queue can take another word |
| fifo_empty_o | output | 1 | Queue holds no words |
| tx_ready_evt_o | output | 1 | Sticky flag: transfer complete |
| overflow_err_o | output | 1 | Sticky flag: write to a full queue was dropped |

## Verification
The embedded assertions check these on every cycle:
- the queue occupancy never goes beyond its depth;
- a pop never happens on an empty queue;
- each load drives a start bit and each frame ends on a high line;
- the remaining count drops by exactly one per character;
- both sticky flags hold their value until cleared;
- the abort command leaves an idle line and an empty queue.

Only the bench scenarios can show the following, because these depend on whole frames and on the stimulus sequence:
- byte order and the framing on the line;
- that unused upper bytes of a final word are dropped;
- when the event flag rises relative to the last stop bit;
- that words wait while the count is zero.

// File: rtl/uart_word_tx_pkg.sv
package uart_word_tx_pkg;
  localparam int WORD_W      = 32;
  localparam int CHAR_W      = 8;
  localparam int LANES       = WORD_W / CHAR_W;
  localparam int LANE_W      = $clog2(LANES);
  localparam int FRAME_BITS  = CHAR_W + 2;
  localparam int CMD_W       = 2;
  localparam int CMD_RST_TX  = 0;
  localparam int CMD_CLR_EVT = 1;
endpackage

// File: rtl/uwt_word_fifo.sv
module uwt_word_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  // R5
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  // R5
  fifo_no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/uwt_unpack.sv
module uwt_unpack
  import uart_word_tx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              fifo_empty_i,
  input  logic [WORD_W-1:0] fifo_rdata_i,
  output logic              fifo_pop_o,
  input  logic              ser_ready_i,
  output logic              load_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              rem_zero_o
);
  logic [WORD_W-1:0] word_q;
  logic              word_vld_q;
  logic [LANE_W-1:0] lane_q;
  logic [CNT_W-1:0]  rem_q;
  logic              last_lane;

  assign rem_zero_o = (rem_q == '0);
  assign fifo_pop_o = !word_vld_q && !fifo_empty_i && !rem_zero_o && !flush_i;
  assign load_o     = word_vld_q && ser_ready_i && !rem_zero_o && !flush_i;
  assign char_o     = word_q[CHAR_W-1:0];
  assign last_lane  = (lane_q == LANE_W'(LANES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q     <= '0;
      word_vld_q <= 1'b0;
      lane_q     <= '0;
      rem_q      <= '0;
    end else if (flush_i) begin
      word_vld_q <= 1'b0;
      lane_q     <= '0;
      rem_q      <= '0;
    end else begin
      if (fifo_pop_o) begin
        word_q     <= fifo_rdata_i;
        word_vld_q <= 1'b1;
        lane_q     <= '0;
      end else if (load_o) begin
        word_q <= word_q >> CHAR_W;
        lane_q <= lane_q + 1'b1;
        if (last_lane || rem_q == CNT_W'(1)) word_vld_q <= 1'b0;
      end
      if (cnt_we_i)    rem_q <= cnt_wdata_i;
      else if (load_o) rem_q <= rem_q - 1'b1;
    end
  end

  // R4
  rem_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o && !cnt_we_i |=> rem_q == $past(rem_q) - 1'b1);
endmodule

// File: rtl/uwt_serializer.sv
module uwt_serializer
  import uart_word_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              line_o
);
  localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int BW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shift_q;
  logic [BW-1:0]         bit_q;
  logic [TW-1:0]         tick_q;
  logic                  busy_q, done_q, line_q;

  assign ready_o = !busy_q;
  assign done_o  = done_q;
  assign line_o  = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '1;
      bit_q   <= '0;
      tick_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      line_q  <= 1'b1;
    end else if (flush_i) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      line_q  <= 1'b1;
      bit_q   <= '0;
      tick_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_i && !busy_q) begin
        shift_q <= {1'b1, char_i, 1'b0};
        line_q  <= 1'b0;
        busy_q  <= 1'b1;
        bit_q   <= '0;
        tick_q  <= '0;
      end else if (busy_q && tick_i) begin
        if (tick_q == TW'(TICKS_PER_BIT - 1)) begin
          tick_q <= '0;
          if (bit_q == BW'(FRAME_BITS - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            line_q <= 1'b1;
          end else begin
            bit_q   <= bit_q + 1'b1;
            shift_q <= shift_q >> 1;
            line_q  <= shift_q[1];
          end
        end else begin
          tick_q <= tick_q + 1'b1;
        end
      end
    end
  end

  // R3
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !busy_q && !flush_i |=> !line_o);

  // R3
  stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> line_o);
endmodule

// File: rtl/uart_word_tx.sv
module uart_word_tx
  import uart_word_tx_pkg::*;
#(
  parameter int FIFO_DEPTH    = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int CNT_W         = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              data_we_i,
  input  logic [WORD_W-1:0] data_wdata_i,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              baud_tick_i,
  output logic              txd_o,
  output logic              fifo_space_o,
  output logic              fifo_empty_o,
  output logic              tx_ready_evt_o,
  output logic              overflow_err_o
);
  logic              rst_tx, clr_evt;
  logic              fifo_full, fifo_empty, fifo_pop;
  logic [WORD_W-1:0] fifo_rdata;
  logic              ser_ready, ser_done, load;
  logic [CHAR_W-1:0] char_sel;
  logic              rem_zero;
  logic              evt_q, ovf_q;

  assign rst_tx  = cmd_we_i && cmd_i[CMD_RST_TX];
  assign clr_evt = cmd_we_i && cmd_i[CMD_CLR_EVT];

  uwt_word_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rst_tx),
    .push_i  (data_we_i),
    .wdata_i (data_wdata_i),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_rdata),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  uwt_unpack #(.CNT_W(CNT_W)) i_unpack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (rst_tx),
    .cnt_we_i     (cnt_we_i),
    .cnt_wdata_i  (cnt_wdata_i),
    .fifo_empty_i (fifo_empty),
    .fifo_rdata_i (fifo_rdata),
    .fifo_pop_o   (fifo_pop),
    .ser_ready_i  (ser_ready),
    .load_o       (load),
    .char_o       (char_sel),
    .rem_zero_o   (rem_zero)
  );

  uwt_serializer #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rst_tx),
    .tick_i  (baud_tick_i),
    .load_i  (load),
    .char_i  (char_sel),
    .ready_o (ser_ready),
    .done_o  (ser_done),
    .line_o  (txd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (ser_done && rem_zero) evt_q <= 1'b1;
      else if (clr_evt)         evt_q <= 1'b0;
      if (rst_tx)                        ovf_q <= 1'b0;
      else if (data_we_i && fifo_full)   ovf_q <= 1'b1;
    end
  end

  assign fifo_space_o   = !fifo_full;
  assign fifo_empty_o   = fifo_empty;
  assign tx_ready_evt_o = evt_q;
  assign overflow_err_o = ovf_q;

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_err_o && !rst_tx |=> overflow_err_o);

  // R6
  evt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_evt_o && !clr_evt |=> tx_ready_evt_o);

  // R9
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_tx |=> fifo_empty_o && txd_o && !overflow_err_o);
endmodule

// File: tb/test_uart_word_tx.sv
module test_uart_word_tx;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_we = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic        data_we = 1'b0;
  logic [31:0] data_wdata = '0;
  logic        cmd_we = 1'b0;
  logic [1:0]  cmd = '0;
  logic        baud_tick = 1'b0;
  logic        txd, fifo_space, fifo_empty, evt, ovf;

  int checks = 0;
  int errors = 0;
  int tdiv_cnt = 0;
  bit mon_en = 1'b0;
  bit mon_busy = 1'b0;
  bit timeout = 1'b0;
  logic [7:0] exp_q [$];

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tdiv_cnt  <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
    baud_tick <= (tdiv_cnt == TDIV - 1);
  end

  uart_word_tx i_uart_word_tx (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .cnt_we_i       (cnt_we),
    .cnt_wdata_i    (cnt_wdata),
    .data_we_i      (data_we),
    .data_wdata_i   (data_wdata),
    .cmd_we_i       (cmd_we),
    .cmd_i          (cmd),
    .baud_tick_i    (baud_tick),
    .txd_o          (txd),
    .fifo_space_o   (fifo_space),
    .fifo_empty_o   (fifo_empty),
    .tx_ready_evt_o (evt),
    .overflow_err_o (ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: decodes frames on the line and compares against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && txd == 1'b0) begin
        logic [7:0] b;
        logic [7:0] e;
        mon_busy = 1'b1;
        repeat (BITC / 2) @(negedge clk);
        chk(txd == 1'b0, "R3 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BITC) @(negedge clk);
          b[i] = txd;
        end
        repeat (BITC) @(negedge clk);
        chk(txd == 1'b1, "R3 stop bit", txd, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected char", b, 0);
        end else begin
          e = exp_q.pop_front();
          chk(b == e, "R2 char order/value", b, e);
        end
        mon_busy = 1'b0;
      end
    end
  end

  task automatic wr_cnt(input int n);
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = 16'(n);
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic wr_word(input logic [31:0] w);
    @(negedge clk);
    while (!fifo_space) @(negedge clk);
    data_we = 1'b1; data_wdata = w;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wr_cmd(input logic [1:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd = c;
    @(negedge clk); cmd_we = 1'b0; cmd = '0;
  endtask

  // Driver: count, then packed words; bytes above the count are filler 0xA5.
  task automatic send_xfer(input int n, input int seed, input bit track);
    int nw;
    nw = (n + 3) / 4;
    wr_cnt(n);
    for (int w = 0; w < nw; w++) begin
      logic [31:0] word;
      for (int l = 0; l < 4; l++) begin
        int k;
        logic [7:0] c;
        k = w * 4 + l;
        c = (k < n) ? 8'((seed + k * 37) & 8'hFF) : 8'hA5;
        word[l*8 +: 8] = c;
        if (k < n && track) exp_q.push_back(c);
      end
      wr_word(word);
    end
  endtask

  task automatic finish_xfer(input string tag);
    @(negedge clk);
    while (exp_q.size() != 0 || mon_busy) @(negedge clk);
    chk(evt == 1'b0, {"R6 evt low before stop ends ", tag}, evt, 0);
    repeat (48) @(negedge clk);
    chk(evt == 1'b1, {"R6 evt after last stop ", tag}, evt, 1);
    chk(txd == 1'b1, "R3 idle high", txd, 1);
    wr_cmd(2'b10);
    chk(evt == 1'b0, "R7 clear event", evt, 0);
  endtask

  task automatic run_tests();
    int lows;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
    chk(fifo_space == 1'b1, "R1 space", fifo_space, 1);
    chk(evt == 1'b0, "R1 evt", evt, 0);
    chk(ovf == 1'b0, "R1 ovf", ovf, 0);
    mon_en = 1'b1;

    send_xfer(4, 8'h31, 1'b1);
    finish_xfer("n4");
    send_xfer(1, 8'h00, 1'b1);   // R4: three filler bytes dropped
    finish_xfer("n1");
    send_xfer(6, 8'hFF, 1'b1);
    finish_xfer("n6");
    send_xfer(11, 8'h5A, 1'b1);
    finish_xfer("n11");

    // R9: abort mid transfer
    mon_en = 1'b0;
    send_xfer(8, 8'h11, 1'b0);
    repeat (200) @(negedge clk);
    wr_cmd(2'b01);
    chk(txd == 1'b1, "R9 line idle after abort", txd, 1);
    chk(fifo_empty == 1'b1, "R9 fifo flushed", fifo_empty, 1);
    wr_word(32'h4433_2211);
    lows = 0;
    repeat (700) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    chk(lows == 0, "R9 count cleared, word held", lows, 0);
    chk(fifo_empty == 1'b0, "R8 word queued with zero count", fifo_empty, 0);
    wr_cmd(2'b01);
    chk(fifo_empty == 1'b1, "R9 flush held word", fifo_empty, 1);

    // R8: overflow with zero count
    for (int i = 0; i < 8; i++) wr_word(32'hDEAD_0000 + 32'(i));
    chk(fifo_space == 1'b0, "R5 full clears space", fifo_space, 0);
    chk(fifo_empty == 1'b0, "R5 not empty", fifo_empty, 0);
    chk(ovf == 1'b0, "R8 no error at exactly full", ovf, 0);
    @(negedge clk); data_we = 1'b1; data_wdata = 32'hBAD0_BAD0;
    @(negedge clk); data_we = 1'b0;
    chk(ovf == 1'b1, "R8 overflow sets error", ovf, 1);
    chk(txd == 1'b1, "R8 nothing sent at zero count", txd, 1);
    wr_cmd(2'b10);
    chk(ovf == 1'b1, "R7 clear-event leaves error", ovf, 1);
    repeat (20) @(negedge clk);
    chk(ovf == 1'b1, "R8 error sticky", ovf, 1);
    wr_cmd(2'b01);
    chk(ovf == 1'b0, "R9 abort clears error", ovf, 0);
    chk(fifo_empty == 1'b1, "R9 flush full fifo", fifo_empty, 1);
    chk(fifo_space == 1'b1, "R5 space after flush", fifo_space, 1);
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    send_xfer(3, 8'h80, 1'b1);
    finish_xfer("n3 after abort");
    chk(exp_q.size() == 0, "R4 all chars sent", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) chk(1'b0, "watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule